// File: doc/BRIEF.md
# ALU with Signed-Amount Shifter

A purely combinational 32-bit arithmetic and logic unit for a pipelined integer core. Eight operations share one three-bit code: four adder operations (plain add, add with incoming carry, subtract, subtract with borrow), three bitwise operations, and one shift. The unit returns the result together with zero, negative, overflow and carry flags. Whether those flags are kept is the caller's decision and is not made here.

The second operand comes either from a register value or from a 16-bit constant that the unit widens itself. The widening rule depends on the operation. For the shift, that operand is read as a signed number. A non-negative value shifts left by that distance. A negative value shifts right by its magnitude, with zero fill or sign fill chosen by a select pin. The block has no states and no clock. All outputs settle from the inputs within one evaluation.

Top module: `alu_sa_top`

## Requirements
- R1: Code 3'b000 is add. The result is a + b modulo 2^32, and C is the carry out of bit 31.
- R2: Code 3'b001 gives a + b + carry_in. Code 3'b010 gives a + ~b + 1. Code 3'b011 gives a + ~b + carry_in. In each of these, C is the carry out of bit 31 of that sum.
- R3: Code 3'b100 is bitwise AND, 3'b101 is OR and 3'b110 is XOR. Each clears both V and C.
- R4: When imm_sel is 1 and the code is not 3'b111, the constant fills bits 31:16 if imm_hi is 1 and bits 15:0 otherwise. The other half is all ones for AND (3'b100) and all zeros for every other code. When imm_sel is 0, opnd_b is used unchanged.
- R5: When imm_sel is 1 and the code is 3'b111, the constant is sign-extended from bit 15. imm_hi has no effect in this case.
- R6: For code 3'b111, a second operand from 1 to 31 shifts opnd_a left by that distance with zero fill. C is the last bit shifted out, which is a[32-distance].
- R7: For code 3'b111, a second operand from -1 to -31 shifts right by its magnitude. Fill is zero when shift_arith is 0 and a[31] when shift_arith is 1. C is 0.
- R8: For code 3'b111, a second operand of 0 returns opnd_a unchanged, with C = 0.
- R9: For every operation, Z is 1 exactly when the result is zero, and N equals result bit 31.
- R10: For codes 3'b000 to 3'b011, V is 1 when a and the adder's second input (b, or ~b when subtracting) share a sign that differs from the result's sign. For logic and shift codes, V is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Register form of the second operand |
| imm_val | input | 16 | Constant used for the immediate form |
| imm_sel | input | 1 | 1: second operand is built from imm_val |
| imm_hi | input | 1 | 1: constant goes to the upper half |
| op_code | input | 3 | Operation select |
| carry_in | input | 1 | Stored carry flag, used by codes 001 and 011 |
| shift_arith | input | 1 | 1: right shifts fill with a[31] |
| result | output | 32 | Operation result |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result bit 31 |
| flag_v | output | 1 | Signed overflow of the adder |
| flag_c | output | 1 | Adder carry, or last bit out of a left shift |

## Verification
Two things coincide in a single evaluation: widening the constant, and using that constant as the shift amount. When imm_sel is 1 and the code selects the shift, the 16-bit constant becomes a signed amount, so a constant of 0xFFFF with imm_hi = 1 must still shift right by one rather than build a high-half word. The sweeps drive every opcode with imm_sel set, with both values of imm_hi, and with constants on either side of bit 15. The expected values are computed with bench arithmetic, so each mismatch points either at the widening step or at the shift direction.

// File: rtl/alu_sa_pkg.sv
package alu_sa_pkg;
    typedef enum logic [2:0] {
        OP_ADD   = 3'b000,
        OP_ADDC  = 3'b001,
        OP_SUB   = 3'b010,
        OP_SUBB  = 3'b011,
        OP_AND   = 3'b100,
        OP_OR    = 3'b101,
        OP_XOR   = 3'b110,
        OP_SHIFT = 3'b111
    } alu_op_e;
endpackage

// File: rtl/alu_imm_expand.sv
module alu_imm_expand
    import alu_sa_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input  logic [IMM_W-1:0] imm_val,
    input  logic             imm_hi,
    input  alu_op_e          op,
    output logic [WIDTH-1:0] wide_val
);
    localparam int FILL_W = WIDTH - IMM_W;

    logic [FILL_W-1:0] fill;

    always_comb begin
        fill = (op == OP_AND) ? {FILL_W{1'b1}} : {FILL_W{1'b0}};
        if (op == OP_SHIFT)
            wide_val = {{FILL_W{imm_val[IMM_W-1]}}, imm_val};
        else if (imm_hi)
            wide_val = {imm_val, fill};
        else
            wide_val = {fill, imm_val};
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_sa_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alu_op_e          op,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    logic [WIDTH-1:0] b_eff;
    logic             cin;
    logic [WIDTH:0]   wide;

    always_comb begin
        b_eff = (op == OP_SUB || op == OP_SUBB) ? ~b : b;
        unique case (op)
            OP_ADD:  cin = 1'b0;
            OP_SUB:  cin = 1'b1;
            default: cin = carry_in;
        endcase
        wide = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
        sum  = wide[WIDTH-1:0];
        cout = wide[WIDTH];
        ovf  = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] amount,
    input  logic             arith,
    output logic [WIDTH-1:0] res,
    output logic             cout
);
    localparam int AW = $clog2(WIDTH);

    logic [WIDTH-1:0] neg_amount;
    logic [AW-1:0]    dist_l;
    logic [AW-1:0]    dist_r;
    logic [WIDTH:0]   left_wide;

    always_comb begin
        neg_amount = -amount;
        dist_l     = amount[AW-1:0];
        dist_r     = neg_amount[AW-1:0];
        left_wide  = {1'b0, a} << dist_l;
        if (amount[WIDTH-1]) begin
            res  = arith ? WIDTH'($signed(a) >>> dist_r) : (a >> dist_r);
            cout = 1'b0;
        end else begin
            res  = left_wide[WIDTH-1:0];
            cout = left_wide[WIDTH];
        end
    end
endmodule

// File: rtl/alu_sa_top.sv
module alu_sa_top
    import alu_sa_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [IMM_W-1:0] imm_val,
    input  logic             imm_sel,
    input  logic             imm_hi,
    input  logic [2:0]       op_code,
    input  logic             carry_in,
    input  logic             shift_arith,
    output logic [WIDTH-1:0] result,
    output logic             flag_z,
    output logic             flag_n,
    output logic             flag_v,
    output logic             flag_c
);
    alu_op_e          op;
    logic [WIDTH-1:0] imm_wide;
    logic [WIDTH-1:0] b_sel;
    logic [WIDTH-1:0] as_sum;
    logic             as_c;
    logic             as_v;
    logic [WIDTH-1:0] sh_res;
    logic             sh_c;

    assign op    = alu_op_e'(op_code);
    assign b_sel = imm_sel ? imm_wide : opnd_b;

    alu_imm_expand #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_imm (
        .imm_val (imm_val),
        .imm_hi  (imm_hi),
        .op      (op),
        .wide_val(imm_wide)
    );

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a       (opnd_a),
        .b       (b_sel),
        .op      (op),
        .carry_in(carry_in),
        .sum     (as_sum),
        .cout    (as_c),
        .ovf     (as_v)
    );

    alu_shifter #(.WIDTH(WIDTH)) u_shift (
        .a     (opnd_a),
        .amount(b_sel),
        .arith (shift_arith),
        .res   (sh_res),
        .cout  (sh_c)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBB: begin
                result = as_sum;
                flag_v = as_v;
                flag_c = as_c;
            end
            OP_AND: begin
                result = opnd_a & b_sel;
                flag_v = 1'b0;
                flag_c = 1'b0;
            end
            OP_OR: begin
                result = opnd_a | b_sel;
                flag_v = 1'b0;
                flag_c = 1'b0;
            end
            OP_XOR: begin
                result = opnd_a ^ b_sel;
                flag_v = 1'b0;
                flag_c = 1'b0;
            end
            default: begin
                result = sh_res;
                flag_v = 1'b0;
                flag_c = sh_c;
            end
        endcase
        flag_z = ~|result;
        flag_n = result[WIDTH-1];
    end

    always_comb begin
        if (!$isunknown({opnd_a, opnd_b, imm_val, imm_sel, imm_hi, op_code, carry_in, shift_arith})) begin
            if (op == OP_AND || op == OP_OR || op == OP_XOR)
                AST_LOGIC_CLEARS_VC: assert (!flag_v && !flag_c); // R3
            if (op == OP_ADD)
                AST_ADD_INVERTIBLE: assert (result - b_sel == opnd_a); // R1
            if (op == OP_SHIFT && b_sel == '0)
                AST_SHIFT_ZERO_IDENTITY: assert (result == opnd_a && !flag_c); // R8
            if (op == OP_SHIFT && b_sel[WIDTH-1])
                AST_RIGHT_NO_CARRY: assert (!flag_c); // R7
            if (op == OP_SHIFT)
                AST_SHIFT_NO_OVERFLOW: assert (!flag_v); // R10
            if (imm_sel && op == OP_AND && !imm_hi)
                AST_AND_UPPER_ONES: assert (b_sel[WIDTH-1:IMM_W] == '1); // R4
        end
    end
endmodule

// File: tb/tb_alu_sa_top.sv
module tb_alu_sa_top;
    logic        clk = 1'b0;
    logic [31:0] opnd_a, opnd_b;
    logic [15:0] imm_val;
    logic        imm_sel, imm_hi, carry_in, shift_arith;
    logic [2:0]  op_code;
    logic [31:0] result;
    logic        flag_z, flag_n, flag_v, flag_c;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    alu_sa_top dut (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .imm_val(imm_val), .imm_sel(imm_sel),
        .imm_hi(imm_hi), .op_code(op_code), .carry_in(carry_in),
        .shift_arith(shift_arith), .result(result), .flag_z(flag_z),
        .flag_n(flag_n), .flag_v(flag_v), .flag_c(flag_c)
    );

    function automatic logic [31:0] pat(input int i);
        case (i)
            0: pat = 32'h0000_0000;
            1: pat = 32'h0000_0001;
            2: pat = 32'hFFFF_FFFF;
            3: pat = 32'h8000_0000;
            4: pat = 32'h7FFF_FFFF;
            5: pat = 32'h1234_5678;
            6: pat = 32'hDEAD_BEEF;
            default: pat = 32'h5555_AAAA;
        endcase
    endfunction

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // expected values from plain arithmetic on the effective second operand
    task automatic run(input string rq, input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b_eff_in, input logic ci, input logic ar);
        logic [32:0] w;
        logic [31:0] er, bx;
        logic        ev, ec;
        int          s;
        ev = 1'b0; ec = 1'b0; er = '0;
        case (op)
            3'd0, 3'd1, 3'd2, 3'd3: begin
                bx = (op >= 3'd2) ? ~b_eff_in : b_eff_in;
                w  = {1'b0, a} + {1'b0, bx} + ((op == 3'd0) ? 33'd0 : (op == 3'd2) ? 33'd1 : {32'd0, ci});
                er = w[31:0]; ec = w[32];
                ev = (a[31] == bx[31]) && (er[31] != a[31]);
            end
            3'd4: er = a & b_eff_in;
            3'd5: er = a | b_eff_in;
            3'd6: er = a ^ b_eff_in;
            default: begin
                s = $signed(b_eff_in);
                if (s >= 0) begin
                    w = {1'b0, a} << s;
                    er = w[31:0]; ec = w[32];
                end else begin
                    er = ar ? 32'($signed(a) >>> (-s)) : (a >> (-s));
                end
            end
        endcase
        #2;
        chk(rq, "result", result, er);
        chk(rq, "carry", {31'd0, flag_c}, {31'd0, ec});
        chk("R10", "overflow", {31'd0, flag_v}, {31'd0, ev});
        chk("R9", "zero", {31'd0, flag_z}, {31'd0, (er == 0)});
        chk("R9", "negative", {31'd0, flag_n}, {31'd0, er[31]});
        @(negedge clk);
    endtask

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: tag_of = "R1";
            3'd1, 3'd2, 3'd3: tag_of = "R2";
            3'd4, 3'd5, 3'd6: tag_of = "R3";
            default: tag_of = "R6";
        endcase
    endfunction

    initial begin
        opnd_a = '0; opnd_b = '0; imm_val = '0; imm_sel = 1'b0; imm_hi = 1'b0;
        op_code = 3'd0; carry_in = 1'b0; shift_arith = 1'b0;
        @(negedge clk);
        // idle inputs: add of zeros gives zero with Z set
        run("R1", 3'd0, 32'd0, 32'd0, 1'b0, 1'b0);

        // register-operand sweep over adder and logic codes, R1 R2 R3 R10
        for (int op = 0; op < 7; op++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    for (int c = 0; c < 2; c++) begin
                        op_code = 3'(op); opnd_a = pat(i); opnd_b = pat(j);
                        carry_in = 1'(c); imm_sel = 1'b0;
                        run(tag_of(3'(op)), 3'(op), pat(i), pat(j), 1'(c), 1'b0);
                    end

        // shift sweep through register operand, R6 R7 R8
        for (int s = -31; s < 32; s++)
            for (int i = 2; i < 7; i++)
                for (int ar = 0; ar < 2; ar++) begin
                    op_code = 3'd7; opnd_a = pat(i); opnd_b = 32'(s);
                    shift_arith = 1'(ar); imm_sel = 1'b0;
                    run((s > 0) ? "R6" : (s < 0) ? "R7" : "R8", 3'd7, pat(i), 32'(s), 1'b0, 1'(ar));
                end

        // immediate forms, R4 for adder and logic codes, R5 for the shift
        for (int op = 0; op < 8; op++)
            for (int h = 0; h < 2; h++)
                for (int k = 0; k < 4; k++)
                    for (int i = 2; i < 6; i++) begin
                        logic [15:0] iv;
                        logic [31:0] bw;
                        case (k)
                            0: iv = 16'h0001;
                            1: iv = 16'h8000;
                            2: iv = 16'hFFFF;
                            default: iv = 16'h001F;
                        endcase
                        if (op == 7) bw = {{16{iv[15]}}, iv};
                        else if (h == 1) bw = {iv, (op == 4) ? 16'hFFFF : 16'h0000};
                        else bw = {(op == 4) ? 16'hFFFF : 16'h0000, iv};
                        if (op == 7 && k == 1) continue;
                        op_code = 3'(op); opnd_a = pat(i); opnd_b = 32'hA5A5_A5A5;
                        imm_val = iv; imm_hi = 1'(h); imm_sel = 1'b1;
                        carry_in = 1'b1; shift_arith = 1'b1;
                        run((op == 7) ? "R5" : "R4", 3'(op), pat(i), bw, 1'b1, 1'b1);
                    end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule